// File: doc/BRIEF.md
# Scan-Register Peripheral Bus Bridge

The bridge turns a 16-bit boundary-scan user data register into a master on a small on-chip peripheral bus. A host shifts a command word in over the serial scan port. The word holds a peripheral number, an opcode and a data byte. When the scan is committed, the bridge issues exactly one transaction in the system-clock domain. That transaction is a single-cycle chip select together with either a write strobe or a read strobe.

Write data goes out on a shared byte bus. Each readable peripheral drives its own byte into the bridge. On a read, the bridge keeps the addressed peripheral's byte. The capture phase of the following scan puts that byte in the low byte of the shift register, so the host collects it on the serial output. A read therefore takes two scans.

The scan-side strobes (select, capture, shift, update) arrive already decoded from a boundary-scan controller. The commit event crosses into the system clock through a toggle, a two-stage synchronizer and an edge detector.

Top module: `scan_bus_bridge`

## Requirements
- R1: After the active-low asynchronous reset, all chip selects, `wr_o`, `rd_o` and `wdata_o` are zero. The first scan shifts out 0x0000.
- R2: The register is 16 bits long and shifts least-significant bit first. While a scan is selected, every shift-clock edge with `shift_i` high moves `tdi_i` into bit 15. Bit 0 is always visible on `tdo_o`, so the 16 bits shifted out are the word loaded at capture.
- R3: Command fields: bits [15:12] are the peripheral number, bits [11:8] the opcode and bits [7:0] the data byte. Write and read strobes are never high together.
- R4: The peripheral number drives the one-hot chip select `cs_o[n]`. At most one chip select is high in any cycle, and peripherals 0 and 15 are both reachable.
- R5: Opcode 0x0 is a write. It asserts `cs_o[n]` and `wr_o` for one system-clock cycle, with `wdata_o` equal to the command's data byte.
- R6: Opcode 0x1 is a read. It asserts `cs_o[n]` and `rd_o` for one cycle and keeps byte n of `rdata_i` (bits [8n+7:8n]). The next scan's capture loads {upper byte of the last committed command, kept read byte}.
- R7: Any opcode other than 0x0 and 0x1 produces no chip select and no strobe, and leaves the kept read byte unchanged.
- R8: Each committed scan yields exactly one transaction pulse that lasts one system-clock cycle. With no pending commit, all chip selects and strobes stay low.
- R9: With `sel_i` low, capture, shift and update edges change no state and issue no transaction.
- R10: `wdata_o` holds the data byte of the last committed command and stays stable while the next scan is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Scan data-register clock |
| sel_i | input | 1 | This user register is selected |
| capture_i | input | 1 | Capture strobe: parallel load on next tck edge |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe: commit the shifted word |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (register bit 0) |
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| cs_o | output | 16 | One-hot peripheral chip selects |
| wr_o | output | 1 | Write strobe |
| rd_o | output | 1 | Read strobe |
| wdata_o | output | 8 | Write data byte |
| rdata_i | input | 128 | Read bytes, peripheral n on bits [8n+7:8n] |

## Verification
The bench addresses peripherals 0, 2, 5, 12 and 15. A reversed or misplaced field would then pulse the wrong chip select or return the wrong byte. Read commands are followed by a scan that must return the kept byte under the previous command's upper byte. A read path that skipped the capture load, or read the wrong lane, would shift out a stale or foreign byte.

Two opcodes outside 0x0 and 0x1 are committed, and so is a full scan with select low. A bridge that decoded loosely would emit a spurious pulse or disturb the returned word. Every system clock is compared against a queue of expected transactions. A synchronizer without the edge detector would stretch a pulse or repeat it, and a lost commit would leave the queue non-empty.

// File: rtl/scan_bridge_pkg.sv
package scan_bridge_pkg;
  localparam int unsigned SEL_W_DEF = 4;
  localparam int unsigned OP_W_DEF  = 4;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned OP_WRITE = 0;
  localparam int unsigned OP_READ  = 1;
endpackage

// File: rtl/scan_dr_shifter.sv
module scan_dr_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] rback_i,
  output logic              tdo_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              upd_tgl_o
);
  logic [WORD_W-1:0] sr_q, cmd_q;
  logic              tgl_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cmd_q <= '0;
      tgl_q <= 1'b0;
    end else if (sel_i) begin
      if (capture_i)    sr_q <= {cmd_q[WORD_W-1:DATA_W], rback_i};
      else if (shift_i) sr_q <= {tdi_i, sr_q[WORD_W-1:1]};
      if (update_i) begin
        cmd_q <= sr_q;
        tgl_q <= ~tgl_q;
      end
    end
  end

  assign tdo_o     = sr_q[0];
  assign cmd_o     = cmd_q;
  assign upd_tgl_o = tgl_q;

  // R9
  sel_idle_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> ($stable(sr_q) && $stable(cmd_q) && $stable(tgl_q)));
endmodule

// File: rtl/commit_sync.sv
module commit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], tgl_i};
  end

  // edge of the synchronized toggle marks one commit
  assign pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];

  // R8
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/bus_issuer.sv
module bus_issuer
  import scan_bridge_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WORD_W = SEL_W + OP_W + DATA_W,
  localparam int unsigned N_PER  = 1 << SEL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  logic [WORD_W-1:0]       cmd_i,
  input  logic [N_PER*DATA_W-1:0] rdata_i,
  output logic [N_PER-1:0]        cs_o,
  output logic                    wr_o,
  output logic                    rd_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic [DATA_W-1:0]       rback_o
);
  logic [SEL_W-1:0] per;
  logic [OP_W-1:0]  op;
  logic             is_wr, is_rd;
  logic [N_PER-1:0] per_hot;

  assign per   = cmd_i[WORD_W-1 -: SEL_W];
  assign op    = cmd_i[DATA_W +: OP_W];
  assign is_wr = (op == OP_W'(OP_WRITE));
  assign is_rd = (op == OP_W'(OP_READ));

  for (genvar g = 0; g < N_PER; g++) begin : g_dec
    assign per_hot[g] = (per == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o    <= '0;
      wr_o    <= 1'b0;
      rd_o    <= 1'b0;
      wdata_o <= '0;
      rback_o <= '0;
    end else begin
      cs_o    <= '0;
      wr_o    <= 1'b0;
      rd_o    <= 1'b0;
      wdata_o <= cmd_i[DATA_W-1:0];
      if (fire_i && (is_wr || is_rd)) begin
        cs_o <= per_hot;
        wr_o <= is_wr;
        rd_o <= is_rd;
        if (is_rd) rback_o <= rdata_i[per*DATA_W +: DATA_W];
      end
    end
  end

  // R4
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o));
  // R5
  strobe_has_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || rd_o) |-> (cs_o != '0));
  // R7
  cs_has_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |-> (wr_o || rd_o));
  // R8
  cs_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |=> (cs_o == '0));
  // R6
  rback_only_on_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_o |-> $stable(rback_o));
endmodule

// File: rtl/scan_bus_bridge.sv
module scan_bus_bridge
  import scan_bridge_pkg::*;
#(
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned OP_W   = OP_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W = SEL_W + OP_W + DATA_W,
  localparam int unsigned N_PER  = 1 << SEL_W
) (
  input  logic                    tck_i,
  input  logic                    sel_i,
  input  logic                    capture_i,
  input  logic                    shift_i,
  input  logic                    update_i,
  input  logic                    tdi_i,
  output logic                    tdo_o,
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic [N_PER-1:0]        cs_o,
  output logic                    wr_o,
  output logic                    rd_o,
  output logic [DATA_W-1:0]       wdata_o,
  input  logic [N_PER*DATA_W-1:0] rdata_i
);
  logic [WORD_W-1:0] cmd;
  logic [DATA_W-1:0] rback;
  logic              upd_tgl, fire;

  scan_dr_shifter #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_shift (
    .tck_i, .rst_ni, .sel_i, .capture_i, .shift_i, .update_i, .tdi_i,
    .rback_i(rback), .tdo_o, .cmd_o(cmd), .upd_tgl_o(upd_tgl)
  );

  commit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .tgl_i(upd_tgl), .pulse_o(fire)
  );

  bus_issuer #(.SEL_W(SEL_W), .OP_W(OP_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni, .fire_i(fire), .cmd_i(cmd), .rdata_i,
    .cs_o, .wr_o, .rd_o, .wdata_o, .rback_o(rback)
  );
endmodule

// File: tb/sim_scan_bus_bridge.sv
`timescale 1ns/1ps
module sim_scan_bus_bridge;
  typedef struct {
    logic [15:0] cs;
    logic        wr;
    logic        rd;
    logic [7:0]  wd;
  } txn_t;

  logic tck = 0, sel = 0, cap = 0, shf = 0, upd = 0, tdi = 0;
  logic clk = 0, rst_n = 0;
  logic tdo, wr, rd;
  logic [15:0]  cs;
  logic [7:0]   wdata;
  logic [127:0] rdata;

  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  txn_t exp_q[$];
  logic [7:0] up_m = 0, rb_m = 0, wd_m = 0;

  always #4 clk = ~clk; // 125 MHz

  scan_bus_bridge u0 (
    .tck_i(tck), .sel_i(sel), .capture_i(cap), .shift_i(shf), .update_i(upd),
    .tdi_i(tdi), .tdo_o(tdo), .clk_i(clk), .rst_ni(rst_n),
    .cs_o(cs), .wr_o(wr), .rd_o(rd), .wdata_o(wdata), .rdata_i(rdata)
  );

  function automatic logic [7:0] per_byte(int k);
    return 8'h3C + 8'(k * 17);
  endfunction

  initial for (int k = 0; k < 16; k++) rdata[k*8 +: 8] = per_byte(k);

  // per-clock comparison against expected transaction queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs != 16'h0) begin
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_errors++;
          $display("FAIL R8 unexpected pulse cs=%h wr=%b rd=%b exp none", cs, wr, rd);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          if (cs !== t.cs || wr !== t.wr || rd !== t.rd || (t.wr && wdata !== t.wd)) begin
            mon_errors++;
            $display("FAIL R5/R6 txn got cs=%h wr=%b rd=%b wd=%h exp cs=%h wr=%b rd=%b wd=%h",
                     cs, wr, rd, wdata, t.cs, t.wr, t.rd, t.wd);
          end
        end
      end else if (wr || rd) begin
        mon_checks++;
        mon_errors++;
        $display("FAIL R8 strobe without cs wr=%b rd=%b exp 0 0", wr, rd);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  task automatic tck_pulse();
    #20 tck = 1;
    #20 tck = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #2;
    exp_q.delete();
    up_m = 0; rb_m = 0; wd_m = 0;
    @(negedge clk);
    chk(cs == 0 && !wr && !rd && wdata == 0, "R1 outputs in reset", {cs[7:0], wdata}, 16'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic scan(input logic [15:0] cmd, input logic s, input string tag);
    logic [15:0] got, exp_w;
    @(negedge clk);
    #2;
    exp_w = {up_m, rb_m};
    sel = s;
    cap = 1;
    tck_pulse();
    cap = 0;
    shf = 1;
    for (int i = 0; i < 16; i++) begin
      tdi = cmd[i];
      #10 got[i] = tdo;
      if (i == 8 && s) chk(wdata == wd_m, "R10 wdata stable during shift", {8'h0, wdata}, {8'h0, wd_m});
      #10 tck = 1;
      #20 tck = 0;
    end
    shf = 0;
    upd = 1;
    #20 tck = 1;
    if (s) begin
      up_m = cmd[15:8];
      wd_m = cmd[7:0];
      if (cmd[11:8] == 4'h0)
        exp_q.push_back('{cs: 16'(1) << cmd[15:12], wr: 1'b1, rd: 1'b0, wd: cmd[7:0]});
      else if (cmd[11:8] == 4'h1) begin
        exp_q.push_back('{cs: 16'(1) << cmd[15:12], wr: 1'b0, rd: 1'b1, wd: 8'h0});
        rb_m = per_byte(int'(cmd[15:12]));
      end
    end
    #20 tck = 0;
    upd = 0;
    sel = 0;
    if (s) chk(got == exp_w, {tag, " tdo word"}, got, exp_w);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R8 commit produced its pulse", 16'(exp_q.size()), 16'h0);
    chk(wdata == wd_m, "R10 wdata follows last commit", {8'h0, wdata}, {8'h0, wd_m});
  endtask

  initial begin
    do_reset();
    scan(16'h2034, 1, "R1 R2 first scan zero");     // write p2
    scan(16'hF0A5, 1, "R2 R3 R5");                  // write p15
    scan(16'h5100, 1, "R4 R5");                     // read p5
    scan(16'h0000, 1, "R6 readback p5");            // write p0
    scan(16'h0177, 1, "R4 R5 p0");                  // read p0
    scan(16'h37FF, 1, "R6 readback p0");            // ignored op 7
    scan(16'h4200, 1, "R7 op7 kept byte");          // ignored op 2
    scan(16'h9099, 0, "R9");                        // deselected
    scan(16'hC1AB, 1, "R7 R9 unchanged word");      // read p12
    scan(16'h8055, 1, "R6 readback p12");
    do_reset();
    scan(16'h0000, 1, "R1 zero after reset");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end

  initial begin
    #1000000;
    $display("FAIL watchdog expired got running exp done");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end
endmodule